// File: doc/BRIEF.md
# Iterative CORDIC tanh Engine

This engine evaluates the hyperbolic tangent of one signed 16-bit fixed-point argument at a time. It uses only shifts, additions and a small table of arctanh constants, and contains no multiplier. The work runs in two passes, each advancing one micro-rotation per clock. The first pass is a hyperbolic rotation. It starts from a pre-scaled unit vector and drives the angle register toward zero, which leaves cosh and sinh of the argument in the x and y registers. The second pass is a linear vectoring pass. It drives y to zero while it builds the quotient sinh/cosh in the angle register, and that quotient is the result.

A caller raises `start_i` for one cycle with the argument on `arg_i` while `busy_o` is low. `busy_o` then stays high for the whole computation. `done_o` pulses once when the new result appears on `result_o`, and the result holds there until the next completion. The number of micro-rotations per pass is a parameter, so accuracy is traded against latency. Arguments beyond the convergence range of the hyperbolic pass are clamped to the edge of that range.

Top module: `tanh_cordic_engine`

## Requirements
- R1: While reset is held low and in the first cycle after its release, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A `start_i` sampled high while `busy_o` is low is accepted, and `busy_o` is high in the following cycle.
- R3: A `start_i` raised while `busy_o` is high has no effect: the running result is unchanged and no extra `done_o` pulse occurs.
- R4: `done_o` goes high exactly 2·ITER clock cycles after the edge that accepted the start, and it stays high for exactly one cycle. In that cycle `busy_o` is low.
- R5: `result_o` changes only in the cycle in which `done_o` is high, and it holds its value at all other times.
- R6: `arg_i` is a Q3.12 value and `result_o` is a Q2.14 value. For arguments with magnitude up to 4575 (about 1.1169), and with ITER = 16, `result_o` is within 4 LSB of 16384·tanh(arg/4096).
- R7: Any argument above 4575 is treated as 4575, and any argument below −4575 is treated as −4575. The result is then within 4 LSB of ±16384·tanh(4575/4096).
- R8: A start raised in the same cycle that `done_o` is high is accepted. Its result follows 2·ITER cycles after that edge.
- R9: The magnitude of `result_o` never exceeds 16383, which is one LSB below unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a computation |
| arg_i | input | 16 | Signed argument, Q3.12 |
| busy_o | output | 1 | High while a computation runs |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Signed tanh result, Q2.14 |

## Verification
The completion pulse of one computation and the acceptance of the next start can fall in the same cycle. The engine is already idle when `done_o` is high. The bench's driver waits only for `busy_o` to be low, so each new request is raised exactly in the done cycle of the previous one. The judgement rests on three checks. The previous result must match its real-valued tanh reference. `busy_o` must be high in the next cycle. The new result must arrive exactly 2·ITER cycles later with its own correct value. A start raised mid-computation is also used to show that an overlapping request is dropped and does not corrupt the result in flight.

// File: rtl/tanh_cordic_pkg.sv
package tanh_cordic_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HYP  = 2'd1,
        PH_LIN  = 2'd2
    } phase_e;

    // arctanh(2^-i) as a fixed-point value with fb fraction bits,
    // summed from the odd power series in 62-bit fixed point.
    function automatic logic [63:0] atanh_fix(input int i, input int fb);
        logic [63:0] acc;
        int          p;
        acc = '0;
        if (i < 1) begin
            return '0;
        end
        for (int k = 0; k < 32; k++) begin
            p = 62 - i * (2 * k + 1);
            if (p >= 0) begin
                acc = acc + ((64'd1 << p) / 64'(2 * k + 1));
            end
        end
        return (acc + (64'd1 << (61 - fb))) >> (62 - fb);
    endfunction

    // Shift indices of the hyperbolic pass that are run twice
    function automatic logic is_repeat(input int s);
        return (s == 4) || (s == 13) || (s == 40);
    endfunction

endpackage

// File: rtl/tanh_cordic_atanh_rom.sv
module tanh_cordic_atanh_rom #(
    parameter int W  = 24,
    parameter int FB = 20,
    parameter int IW = 6
) (
    input  logic [IW-1:0]        idx_i,
    output logic signed [W-1:0]  ang_o
);
    localparam int N = 1 << IW;

    logic signed [W-1:0] tab [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        localparam logic [63:0] V = tanh_cordic_pkg::atanh_fix(g, FB);
        assign tab[g] = W'(V);
    end

    assign ang_o = tab[idx_i];
endmodule

// File: rtl/tanh_cordic_clamp.sv
module tanh_cordic_clamp #(
    parameter int IN_W    = 16,
    parameter int IN_F    = 12,
    parameter int W       = 24,
    parameter int FB      = 20,
    parameter int ARG_LIM = 4575
) (
    input  logic signed [IN_W-1:0] arg_i,
    output logic signed [W-1:0]    z0_o
);
    localparam logic signed [IN_W-1:0] HI = IN_W'(ARG_LIM);
    localparam logic signed [IN_W-1:0] LO = -HI;
    localparam int UP = FB - IN_F;

    logic signed [IN_W-1:0] cl;
    logic signed [W-1:0]    wide;

    always_comb begin
        if (arg_i > HI) begin
            cl = HI;
        end else if (arg_i < LO) begin
            cl = LO;
        end else begin
            cl = arg_i;
        end
        wide = {{(W-IN_W){cl[IN_W-1]}}, cl};
        z0_o = wide <<< UP;
    end
endmodule

// File: rtl/tanh_cordic_rotator.sv
module tanh_cordic_rotator #(
    parameter int W  = 24,
    parameter int SW = 6
) (
    input  logic                hyp_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic signed [W-1:0] z_i,
    input  logic signed [W-1:0] ang_i,
    input  logic [SW-1:0]       sh_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output logic signed [W-1:0] z_o
);
    logic                fwd;
    logic signed [W-1:0] xs;
    logic signed [W-1:0] ys;

    always_comb begin
        xs  = x_i >>> sh_i;
        ys  = y_i >>> sh_i;
        // hyperbolic rotation steers by angle sign, linear vectoring by y sign
        fwd = hyp_i ? ~z_i[W-1] : y_i[W-1];
        if (fwd) begin
            x_o = hyp_i ? (x_i + ys) : x_i;
            y_o = y_i + xs;
            z_o = z_i - ang_i;
        end else begin
            x_o = hyp_i ? (x_i - ys) : x_i;
            y_o = y_i - xs;
            z_o = z_i + ang_i;
        end
    end
endmodule

// File: rtl/tanh_cordic_engine.sv
module tanh_cordic_engine #(
    parameter int ITER    = 16,
    parameter int IN_W    = 16,
    parameter int IN_F    = 12,
    parameter int OUT_W   = 16,
    parameter int OUT_F   = 14,
    parameter int W       = 24,
    parameter int FB      = 20,
    parameter int ARG_LIM = 4575
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic signed [IN_W-1:0]  arg_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic signed [OUT_W-1:0] result_o
);
    import tanh_cordic_pkg::*;

    localparam int KW = $clog2(ITER + 1);
    localparam int SW = $clog2(ITER + 1) + 1;
    localparam int DROP = FB - OUT_F;
    localparam logic signed [W-1:0] X0 = W'($rtoi(1.2074970677630720 * (2.0 ** FB)));
    localparam logic signed [W-1:0] ONE = W'(1) << FB;
    localparam logic signed [W-1:0] HALF = W'(1) << (DROP - 1);
    localparam logic [KW-1:0] LAST = KW'(ITER - 1);

    typedef struct packed {
        phase_e                   ph;
        logic [KW-1:0]            k;
        logic [SW-1:0]            sh;
        logic                     rep;
        logic signed [W-1:0]      x;
        logic signed [W-1:0]      y;
        logic signed [W-1:0]      z;
        logic signed [OUT_W-1:0]  res;
        logic                     done;
    } st_t;

    st_t st_d, st_q;

    logic signed [W-1:0] z0;
    logic signed [W-1:0] rom_ang;
    logic signed [W-1:0] lin_ang;
    logic signed [W-1:0] ang;
    logic signed [W-1:0] rx, ry, rz;
    logic signed [W-1:0] rnd;
    logic                hyp;

    tanh_cordic_clamp #(
        .IN_W(IN_W), .IN_F(IN_F), .W(W), .FB(FB), .ARG_LIM(ARG_LIM)
    ) i_clamp (
        .arg_i(arg_i),
        .z0_o (z0)
    );

    tanh_cordic_atanh_rom #(
        .W(W), .FB(FB), .IW(SW)
    ) i_rom (
        .idx_i(st_q.sh),
        .ang_o(rom_ang)
    );

    tanh_cordic_rotator #(
        .W(W), .SW(SW)
    ) i_rot (
        .hyp_i(hyp),
        .x_i  (st_q.x),
        .y_i  (st_q.y),
        .z_i  (st_q.z),
        .ang_i(ang),
        .sh_i (st_q.sh),
        .x_o  (rx),
        .y_o  (ry),
        .z_o  (rz)
    );

    always_comb begin
        hyp     = (st_q.ph == PH_HYP);
        lin_ang = ONE >>> st_q.sh;
        ang     = hyp ? rom_ang : lin_ang;
        rnd     = (rz + HALF) >>> DROP;

        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_HYP;
                    st_d.k   = '0;
                    st_d.sh  = SW'(1);
                    st_d.rep = 1'b0;
                    st_d.x   = X0;
                    st_d.y   = '0;
                    st_d.z   = z0;
                end
            end
            PH_HYP: begin
                st_d.x = rx;
                st_d.y = ry;
                st_d.z = rz;
                if (!st_q.rep && is_repeat(int'(st_q.sh))) begin
                    st_d.rep = 1'b1;
                end else begin
                    st_d.rep = 1'b0;
                    st_d.sh  = st_q.sh + 1'b1;
                end
                if (st_q.k == LAST) begin
                    st_d.ph  = PH_LIN;
                    st_d.k   = '0;
                    st_d.sh  = '0;
                    st_d.rep = 1'b0;
                    st_d.z   = '0;
                end else begin
                    st_d.k = st_q.k + 1'b1;
                end
            end
            PH_LIN: begin
                st_d.y  = ry;
                st_d.z  = rz;
                st_d.sh = st_q.sh + 1'b1;
                if (st_q.k == LAST) begin
                    st_d.ph   = PH_IDLE;
                    st_d.res  = rnd[OUT_W-1:0];
                    st_d.done = 1'b1;
                end else begin
                    st_d.k = st_q.k + 1'b1;
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.ph != PH_IDLE);
    assign done_o   = st_q.done;
    assign result_o = st_q.res;
endmodule

// File: rtl/tanh_cordic_engine_chk.sv
module tanh_cordic_engine_chk #(
    parameter int ITER  = 16,
    parameter int OUT_W = 16,
    parameter int OUT_F = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic signed [OUT_W-1:0] result_o
);
    localparam logic signed [OUT_W-1:0] MAXV = OUT_W'((1 << OUT_F) - 1);

    int busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (start_i && !busy_o) begin
            busy_cnt <= 0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == 2 * ITER));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R9
    result_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o <= MAXV) && (result_o >= -MAXV));
endmodule

bind tanh_cordic_engine tanh_cordic_engine_chk #(
    .ITER(ITER), .OUT_W(OUT_W), .OUT_F(OUT_F)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .result_o(result_o)
);

// File: tb/test_tanh_cordic_engine.sv
module test_tanh_cordic_engine;
    localparam int ITER = 16;
    localparam int LIM  = 4575;

    typedef struct {
        int    arg;
        real   expv;
        longint acc;
    } item_t;

    logic               clk;
    logic               rst_n;
    logic               start_i;
    logic signed [15:0] arg_i;
    logic               busy_o;
    logic               done_o;
    logic signed [15:0] result_o;

    int     checks;
    int     errors;
    longint cyc;
    item_t  sb[$];
    logic signed [15:0] last_res;
    logic   prev_done;
    logic   mon_on;

    tanh_cordic_engine #(.ITER(ITER)) i_tanh_cordic_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .arg_i   (arg_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .result_o(result_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic real ref_tanh(input int a);
        int c;
        c = a;
        if (c > LIM) c = LIM;
        if (c < -LIM) c = -LIM;
        return $tanh(real'(c) / 4096.0) * 16384.0;
    endfunction

    // driver: waits for idle, raises start for one cycle, queues expectation
    task automatic launch(input int a);
        item_t it;
        bit    in_done;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        in_done = done_o;
        start_i = 1'b1;
        arg_i   = 16'(a);
        it.arg  = a;
        it.expv = ref_tanh(a);
        it.acc  = cyc + 1;
        sb.push_back(it);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, $sformatf("R2 R8 busy after start (done cycle %0d) act %0d exp 1",
                                      in_done, busy_o));
    endtask

    // monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (done_o) begin
                if (prev_done) begin
                    chk(1'b0, "R4 done held two cycles act 1 exp 0");
                end
                if (sb.size() == 0) begin
                    chk(1'b0, $sformatf("R3 unexpected done act %0d exp none", result_o));
                end else begin
                    item_t it;
                    real   d;
                    it = sb.pop_front();
                    d  = real'(int'(result_o)) - it.expv;
                    if (d < 0.0) d = -d;
                    if ((it.arg > LIM) || (it.arg < -LIM)) begin
                        chk(d <= 4.0, $sformatf("R7 arg %0d act %0d exp %0.2f",
                                                it.arg, result_o, it.expv));
                    end else begin
                        chk(d <= 4.0, $sformatf("R6 arg %0d act %0d exp %0.2f",
                                                it.arg, result_o, it.expv));
                    end
                    chk((cyc - it.acc) == 2 * ITER,
                        $sformatf("R4 latency arg %0d act %0d exp %0d",
                                  it.arg, cyc - it.acc, 2 * ITER));
                    chk((result_o <= 16383) && (result_o >= -16383),
                        $sformatf("R9 magnitude act %0d exp <=16383", result_o));
                end
                last_res = result_o;
            end else begin
                if (result_o != last_res) begin
                    chk(1'b0, $sformatf("R5 result moved act %0d exp %0d", result_o, last_res));
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks    = 0;
        errors    = 0;
        mon_on    = 1'b0;
        prev_done = 1'b0;
        last_res  = '0;
        rst_n     = 1'b0;
        start_i   = 1'b0;
        arg_i     = '0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && (result_o == 0),
            $sformatf("R1 in reset busy %0d done %0d res %0d exp 0 0 0", busy_o, done_o, result_o));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && (result_o == 0),
            $sformatf("R1 after reset busy %0d done %0d res %0d exp 0 0 0", busy_o, done_o, result_o));
        mon_on = 1'b1;

        // R6 zero and range edges
        launch(0);
        launch(LIM);
        launch(-LIM);
        launch(1);
        launch(-1);

        // R6 sweep across the supported range, back to back (R8)
        for (int a = -LIM; a <= LIM; a += 61) begin
            launch(a);
        end

        // R7 clamped arguments
        launch(LIM + 1);
        launch(-LIM - 1);
        launch(8000);
        launch(32767);
        launch(-32768);
        launch(-12000);

        // R3 start while busy is dropped
        launch(2000);
        repeat (5) @(negedge clk);
        start_i = 1'b1;
        arg_i   = 16'(-3000);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, $sformatf("R3 busy kept after overlapping start act %0d exp 1", busy_o));
        launch(-2500);

        while ((sb.size() > 0) || busy_o) @(negedge clk);
        repeat (3 * ITER) @(negedge clk);
        chk(sb.size() == 0, $sformatf("R3 queue drained act %0d exp 0", sb.size()));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule